// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port synchronous SRAM. Reads and writes may follow each other on every clock with no idle cycles in between. Write data trails its command by the same two enabled clocks as read data, so the shared data bus carries a word in every cycle. A write whose data has been taken but not yet stored waits in a short registry. A read that hits such a pending write is served from the registry, merged byte by byte over the stored word.

A command is either loaded with a fresh address or continues the last loaded access through a two-bit burst counter. The counter steps in linear or interleaved order. A clock-enable input freezes the whole pipeline. A sleep input, synchronised over two clocks, parks the device with its outputs off.

Top module: `zbt_sram`

## Requirements
- R1: Any mix of reads and writes issued on consecutive enabled clocks completes with no wait states, and every read returns the most recent data written to that address.
- R2: A read captured at enabled edge N drives its word on `dout` with `dout_en` high from enabled edge N+1, so it is valid at edge N+2. Write data for a command captured at edge N is taken from `din` at enabled edge N+2.
- R3: While `cke_n` is high, a rising edge changes no pipeline state, and `dout` and `dout_en` hold their values.
- R4: `bsel_n[i]` low selects lane i, which is `din[9*i+8:9*i]`, for a write. Lanes whose select is high keep their old contents.
- R5: After the edge where a write enters its data phase, `dout_en` is low, so the device never drives the bus while write data is present.
- R6: A load command is accepted only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. Any other combination is a no-operation that produces no read data and writes nothing.
- R7: With `ld_n` high, an access continues the last loaded command (read or write) at the next burst address. With `order_ilv`=0 at load, the low two address bits step as base+1, base+2, base+3 modulo 4.
- R8: With `order_ilv`=1 at load, the low two address bits step as base XOR 1, base XOR 2, base XOR 3.
- R9: An advance (`ld_n` high) after a deselect, a reset or sleep is a no-operation.
- R10: A read whose address matches one or both writes that have not yet been stored returns their written lanes, the newer one winning, over the stored word.
- R11: `sleep` takes effect two clocks after it rises and releases two clocks after it falls. While the device sleeps, commands are ignored, in-flight accesses are dropped and `dout_en` is low.
- R12: A synchronous active-high `rst` clears all pending accesses, so `dout_en` is low after the reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cke_n | input | 1 | Clock enable, active low |
| ld_n | input | 1 | Low loads a new address, high advances the burst |
| we_n | input | 1 | Write command when low at load |
| bsel_n | input | LANES | Per-lane write selects, active low |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| order_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| sleep | input | 1 | Sleep request |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data |
| dout_en | output | 1 | High while `dout` should drive the bus |

## Verification
The bench captures each command at the edge N where it is given. It models the read word as due right after the first following enabled edge and the write data as taken at the second one. Stalled edges do not count toward either delay. Outputs are compared at the falling edge after every rising edge, so each result is checked in the first half cycle where it is due, and its persistence is checked on the cycles that follow. The sleep state is modelled as a two-stage shift advancing on every clock, whether or not the clock is enabled, so that entry and exit fall on the same edges as in the design.

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cke_n,
  input  logic                      ld_n,
  input  logic                      we_n,
  input  logic [LANES-1:0]          bsel_n,
  input  logic                      sel0_n,
  input  logic                      sel1,
  input  logic                      sel2_n,
  input  logic                      order_ilv,
  input  logic                      sleep,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   din,
  output logic [LANES*LANE_W-1:0]   dout,
  output logic                      dout_en
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic [1:0] slp_q;
  wire asleep = slp_q[1];
  wire go     = !cke_n && !asleep;

  logic [ADDR_W-1:0] base;
  logic [1:0]        cnt;
  logic              ilv_q, last_v, last_we;

  logic              s1_v, s1_we, s2_v, s2_we, wq_v, oe_q;
  logic [ADDR_W-1:0] s1_a, s2_a, wq_a;
  logic [LANES-1:0]  s1_m, s2_m, wq_m;
  logic [DATA_W-1:0] wq_d, dout_q, rd;

  wire              selected = !sel0_n && sel1 && !sel2_n;
  wire [1:0]        cnt_nx   = cnt + 2'd1;
  wire [1:0]        lo_nx    = ilv_q ? (base[1:0] ^ cnt_nx) : (base[1:0] + cnt_nx);
  wire [ADDR_W-1:0] adv_a    = {base[ADDR_W-1:2], lo_nx};
  wire              new_v    = ld_n ? last_v  : selected;
  wire              new_we   = ld_n ? last_we : !we_n;
  wire [ADDR_W-1:0] new_a    = ld_n ? adv_a   : addr;

  assign dout    = dout_q;
  assign dout_en = oe_q;

  always_comb begin
    rd = mem[s1_a];
    for (int i = 0; i < LANES; i++) begin
      if (wq_v && wq_a == s1_a && wq_m[i])
        rd[i*LANE_W +: LANE_W] = wq_d[i*LANE_W +: LANE_W];
      if (s2_v && s2_we && s2_a == s1_a && s2_m[i])
        rd[i*LANE_W +: LANE_W] = din[i*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (wq_v)
      for (int i = 0; i < LANES; i++)
        if (wq_m[i]) mem[wq_a][i*LANE_W +: LANE_W] <= wq_d[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    slp_q <= rst ? 2'b00 : {slp_q[0], sleep};
    wq_v  <= !rst && go && s2_v && s2_we;
    if (go && s2_v && s2_we) begin
      wq_a <= s2_a;
      wq_m <= s2_m;
      wq_d <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || asleep) begin
      s1_v   <= 1'b0;
      s2_v   <= 1'b0;
      oe_q   <= 1'b0;
      last_v <= 1'b0;
    end else if (go) begin
      s1_v  <= new_v;
      s1_we <= new_we;
      s1_a  <= new_a;
      s1_m  <= ~bsel_n;
      s2_v  <= s1_v;
      s2_we <= s1_we;
      s2_a  <= s1_a;
      s2_m  <= s1_m;
      oe_q  <= s1_v && !s1_we;
      if (s1_v && !s1_we) dout_q <= rd;
      if (!ld_n) begin
        base    <= addr;
        cnt     <= 2'd0;
        ilv_q   <= order_ilv;
        last_v  <= selected;
        last_we <= !we_n;
      end else if (last_v) begin
        cnt <= cnt_nx;
      end
    end
  end
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              cke_n,
  input logic              asleep,
  input logic              s1_v,
  input logic              s1_we,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en
);
  p_reset_off_r12: assert property (@(posedge clk) rst |=> !dout_en);

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (cke_n && !asleep) |=> ($stable(dout_en) && $stable(dout)));

  p_sleep_off_r11: assert property (@(posedge clk) disable iff (rst)
    asleep |=> !dout_en);

  p_write_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !asleep && s1_v && s1_we) |=> !dout_en);

  p_read_drive_r2: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !asleep && s1_v && !s1_we) |=> dout_en);
endmodule

bind zbt_sram zbt_sram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
  .clk(clk), .rst(rst), .cke_n(cke_n), .asleep(slp_q[1]),
  .s1_v(s1_v), .s1_we(s1_we), .dout(dout), .dout_en(dout_en)
);

// File: tb/test_zbt_sram.sv
module test_zbt_sram;
  localparam int AW = 10, NL = 4, LW = 9, DW = NL * LW;

  logic clk = 0, rst = 1, cke_n = 0, ld_n = 0, we_n = 1;
  logic sel0_n = 0, sel1 = 1, sel2_n = 0, order_ilv = 0, sleep = 0;
  logic [NL-1:0] bsel_n = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  wire  [DW-1:0] dout;
  wire           dout_en;

  always #4 clk = ~clk;

  zbt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) i_zbt_sram (
    .clk(clk), .rst(rst), .cke_n(cke_n), .ld_n(ld_n), .we_n(we_n), .bsel_n(bsel_n),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n), .order_ilv(order_ilv),
    .sleep(sleep), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en));

  int n_run = 0, n_fail = 0;
  string cur_req = "R12";

  logic [DW-1:0] m_mem [1<<AW];
  logic p1v, p1we, p2v, p2we, blv, blwe, bi, sl0, sl1, eo;
  logic [AW-1:0] p1a, p2a, bb;
  logic [NL-1:0] p1m, p2m;
  logic [1:0] bc;
  logic [DW-1:0] ed;

  task automatic model_reset();
    p1v = 0; p2v = 0; blv = 0; sl0 = 0; sl1 = 0; eo = 0; ed = '0;
  endtask

  task automatic model_edge();
    logic asl, sel;
    logic [1:0] lo;
    asl = sl1; sl1 = sl0; sl0 = sleep;
    if (asl) begin
      p1v = 0; p2v = 0; eo = 0; blv = 0;
    end else if (!cke_n) begin
      if (p2v && p2we)
        for (int i = 0; i < NL; i++)
          if (p2m[i]) m_mem[p2a][i*LW +: LW] = din[i*LW +: LW];
      eo = p1v && !p1we;
      if (eo) ed = m_mem[p1a];
      p2v = p1v; p2we = p1we; p2a = p1a; p2m = p1m;
      p1m = ~bsel_n;
      sel = !sel0_n && sel1 && !sel2_n;
      if (!ld_n) begin
        p1v = sel; p1we = !we_n; p1a = addr;
        bb = addr; bc = 0; bi = order_ilv; blv = sel; blwe = !we_n;
      end else if (blv) begin
        bc = bc + 2'd1;
        lo = bi ? (bb[1:0] ^ bc) : (bb[1:0] + bc);
        p1v = 1; p1we = blwe; p1a = {bb[AW-1:2], lo};
      end else begin
        p1v = 0;
      end
    end
  endtask

  task automatic check();
    n_run++;
    if (dout_en !== eo || (eo && dout !== ed)) begin
      n_fail++;
      $display("FAIL %s: dout_en=%0b dout=%h expected dout_en=%0b dout=%h",
               cur_req, dout_en, dout, eo, ed);
    end
  endtask

  task automatic cyc(input logic ck, input logic ld, input logic we, input logic [NL-1:0] bs,
                     input logic [2:0] cs, input logic ilv, input logic slp, input logic [AW-1:0] a);
    cke_n = ck; ld_n = ld; we_n = we; bsel_n = bs;
    {sel0_n, sel1, sel2_n} = cs; order_ilv = ilv; sleep = slp; addr = a;
    din = {$urandom, $urandom};
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check();
  endtask

  task automatic rd(input logic [AW-1:0] a);  cyc(0, 0, 1, '1, 3'b010, 0, 0, a); endtask
  task automatic wr(input logic [AW-1:0] a, input logic [NL-1:0] bs); cyc(0, 0, 0, bs, 3'b010, 0, 0, a); endtask
  task automatic nop();  cyc(0, 0, 1, '1, 3'b110, 0, 0, '0); endtask
  task automatic adv();  cyc(0, 1, 1, '1, 3'b010, 0, 0, '0); endtask
  task automatic advw(input logic [NL-1:0] bs); cyc(0, 1, 1, bs, 3'b010, 0, 0, '0); endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    cur_req = "R12";
    check();
    rst = 0;
    nop(); nop();

    cur_req = "R2";
    for (int a = 0; a < 64; a++) wr(AW'(a), '0);
    nop(); nop();
    for (int a = 0; a < 64; a++) rd(AW'(a));
    nop(); nop();

    cur_req = "R7";
    cyc(0, 0, 1, '1, 3'b010, 0, 0, 10'd5); adv(); adv(); adv();
    cyc(0, 0, 0, '0, 3'b010, 0, 0, 10'd13); advw(4'b0011); advw('0); advw(4'b1110);
    nop(); nop();
    cyc(0, 0, 1, '1, 3'b010, 0, 0, 10'd12); adv(); adv(); adv(); nop(); nop();

    cur_req = "R8";
    cyc(0, 0, 1, '1, 3'b010, 1, 0, 10'd6); adv(); adv(); adv();
    cyc(0, 0, 1, '1, 3'b010, 1, 0, 10'd9); adv(); adv(); adv(); nop(); nop();

    cur_req = "R4";
    wr(10'd20, 4'b1010); wr(10'd21, 4'b0111); wr(10'd22, 4'b1111); nop();
    rd(10'd20); rd(10'd21); rd(10'd22); nop(); nop();

    cur_req = "R5";
    rd(10'd1); wr(10'd2, '0); rd(10'd3); wr(10'd4, '0); wr(10'd5, '0); rd(10'd6); nop(); nop();

    cur_req = "R10";
    wr(10'd30, 4'b0000); rd(10'd30); rd(10'd30); nop(); nop();
    wr(10'd31, 4'b1100); wr(10'd31, 4'b1010); rd(10'd31); rd(10'd31); rd(10'd31); nop(); nop();

    cur_req = "R3";
    rd(10'd7); cyc(1, 0, 1, '1, 3'b010, 0, 0, 10'd8); cyc(1, 0, 0, '0, 3'b010, 0, 0, 10'd9);
    rd(10'd8); wr(10'd40, '0); cyc(1, 0, 1, '1, 3'b010, 0, 0, 10'd0);
    cyc(1, 0, 1, '1, 3'b010, 0, 0, 10'd0); rd(10'd40); nop(); nop();

    cur_req = "R6";
    for (int c = 0; c < 8; c++) begin
      if (c != 2) cyc(0, 0, 1, '1, 3'(c), 0, 0, 10'd11);
      if (c != 2) cyc(0, 0, 0, '0, 3'(c), 0, 0, 10'd11);
    end
    nop(); nop(); rd(10'd11); nop(); nop();

    cur_req = "R9";
    rd(10'd16); nop(); adv(); adv(); advw('0); nop(); nop(); rd(10'd17); nop(); nop();

    cur_req = "R11";
    rd(10'd33); rd(10'd34);
    for (int k = 0; k < 5; k++) cyc(0, 0, k[0], '0, 3'b010, 0, 1, AW'(35 + k));
    for (int k = 0; k < 5; k++) cyc(0, 0, 1, '1, 3'b010, 0, 0, AW'(35 + k));
    adv(); nop(); nop();
    for (int k = 0; k < 5; k++) rd(AW'(35 + k));
    nop(); nop();

    cur_req = "R1";
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] cs;
      cs = 3'b010;
      if ($urandom % 10 == 0) begin
        cs = 3'($urandom);
        if (cs == 3'b010) cs = 3'b011;
      end
      cyc(($urandom % 10) == 0, ($urandom % 4) == 0, 1'($urandom), 4'($urandom),
          cs, 1'($urandom), 0, AW'($urandom % 64));
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule